// File: doc/BRIEF.md
# Multiplexed ADC Sequence Controller

This block is the digital control front end of a multiplexed sampling converter. It keeps a small sequence memory. Each location holds one conversion setup: a 3-bit input channel, a single-ended/differential choice, a unipolar/bipolar choice, a gain choice, and an end-of-sequence flag. The analog multiplexer and the conversion core sit outside the block. The core is stood in for by a timer of fixed length whose result word arrives on an input port.

Two mode pins select one of three modes:

- **Direct mode:** the conversion setup comes straight from the configuration pins.
- **Program/readback mode:** the same write and read strobes load the sequence memory and read it back over the data bus. Both walk an auto-incrementing location counter.
- **Run mode:** every conversion start uses the setup at the current location and then steps on.

The active-low busy output covers conversions and also the whole time program/readback mode is held. The shutdown and chip-select inputs also decode into nap and sleep indications. Every control strobe is synchronised to the system clock, and its edges are detected there.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `busy_n` is 1, `data_oe` is 0, `nap` and `sleep` are 0, and the active configuration and every memory location read as zero.
- R2: In program mode (`mode_sel` = 2'b10), each rising edge of `wr_n` stores the configuration pins and `pin_eos` into the current location and advances the location. After location DEPTH-1 the location wraps to 0.
- R3: Entering program mode sets the location counter to 0.
- R4: In program mode with `cs_n` low, a low `rd_n` drives the current location onto `data_out`. Bit DATA_W-1 carries the end-of-sequence flag, bits 2:0 the channel, bit 3 differential, bit 4 bipolar and bit 5 gain, and all other bits are 0. The rising edge of `rd_n` advances the location.
- R5: `busy_n` is low for as long as program mode is held. It returns high once `mode_sel` leaves 2'b10, provided no conversion is running.
- R6: A falling edge of `convst_n` that is accepted holds `busy_n` low for exactly CONV_CYCLES clock cycles. At the end, `conv_result` is latched and is driven on `data_out` outside program mode.
- R7: A falling edge of `convst_n` starts nothing in any of these cases: `cs_n` is high, `shdn_n` is low, program mode is active, or a conversion is already running.
- R8: `data_oe` is 1 only when `cs_n` and `rd_n` are both low. A read strobe given while `cs_n` is high does not advance the location.
- R9: In direct mode (`mode_sel[1]` = 0), the active configuration follows the pins while `wr_n` is low. The rising edge of `wr_n` latches the pins, and the latched value is held while `wr_n` stays high.
- R10: In run mode (`mode_sel` = 2'b11), the active configuration is the current location's setup. After each conversion the location advances, or returns to 0 when that location's end-of-sequence flag is set.
- R11: With `shdn_n` low, `nap` is 1 when `cs_n` is low and `sleep` is 1 when `cs_n` is high. With `shdn_n` high, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| convst_n | input | 1 | Conversion start; a falling edge starts a conversion |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| shdn_n | input | 1 | Shutdown request, active low |
| mode_sel | input | 2 | Mode pins: 0x = direct, 10 = program/readback, 11 = run |
| pin_chan | input | 3 | Channel address pins |
| pin_diff | input | 1 | 1 = differential, 0 = single-ended |
| pin_bip | input | 1 | 1 = bipolar, 0 = unipolar |
| pin_gain | input | 1 | Gain select pin |
| pin_eos | input | 1 | End-of-sequence flag to store when programming |
| conv_result | input | DATA_W | Result word from the conversion core |
| busy_n | output | 1 | Low during a conversion or while program mode is held |
| act_chan | output | 3 | Active channel address |
| act_diff | output | 1 | Active differential select |
| act_bip | output | 1 | Active bipolar select |
| act_gain | output | 1 | Active gain select |
| data_out | output | DATA_W | Data bus value: the result, or the readback word in program mode |
| data_oe | output | 1 | Tri-state enable for the data bus |
| nap | output | 1 | Nap power state indication |
| sleep | output | 1 | Sleep power state indication |

## Verification
The assertions assume that `mode_sel` is not changed while a conversion is running. The stability checks for the location counter and the active setup depend on that. They also assume that the configuration pins are held steady for the synchroniser delay after a `wr_n` rising edge.

The stimulus keeps to both assumptions. It waits for `busy_n` to return high before it touches the mode pins. It changes pins, strobes and modes only at falling clock edges, and it leaves at least four cycles between any two changes. That way every edge passes through the two synchroniser stages before the next one arrives.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // one conversion setup; field order fixes the readback bit positions
   typedef struct packed {
      logic       gain;
      logic       bip;
      logic       diff;
      logic [2:0] chan;
   } cfg_t;

   typedef struct packed {
      logic eos;
      cfg_t cfg;
   } entry_t;

   localparam int CFG_W   = $bits(cfg_t);
   localparam int ENTRY_W = $bits(entry_t);

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adc_seq_mem.sv
module adc_seq_mem import adc_seq_pkg::*; #(
   parameter int DEPTH = 16,
   parameter int PTR_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  entry_t           wdata,
   input  logic             ptr_clr,
   input  logic             ptr_inc,
   output entry_t           rdata,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   entry_t store [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else begin
         if (wr_en) store[ptr] <= wdata;
         if (ptr_clr)      ptr <= '0;
         else if (ptr_inc) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   end

   assign rdata = store[ptr];

endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv #(
   parameter int CYCLES = 20,
   parameter int DATA_W = 10,
   localparam int CNT_W = $clog2(CYCLES + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] result_in,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result
);

   logic [CNT_W-1:0] cnt;

   assign busy = (cnt != '0);
   assign done = (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         result <= '0;
      end else begin
         if (start && !busy) cnt <= CNT_W'(CYCLES);
         else if (busy)      cnt <= cnt - 1'b1;
         if (done) result <= result_in;
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
   parameter int DEPTH       = 16,
   parameter int DATA_W      = 10,
   parameter int CONV_CYCLES = 20,
   parameter int SYNC_STAGES = 2,
   localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              convst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              shdn_n,
   input  logic [1:0]        mode_sel,
   input  logic [2:0]        pin_chan,
   input  logic              pin_diff,
   input  logic              pin_bip,
   input  logic              pin_gain,
   input  logic              pin_eos,
   input  logic [DATA_W-1:0] conv_result,
   output logic              busy_n,
   output logic [2:0]        act_chan,
   output logic              act_diff,
   output logic              act_bip,
   output logic              act_gain,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              nap,
   output logic              sleep
);

   localparam int NSYNC = 7;

   // elaboration checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("adc_seq_ctrl: DEPTH must be at least 2");
      end
      if (DATA_W <= CFG_W) begin : g_bad_width
         $error("adc_seq_ctrl: DATA_W must exceed the setup width");
      end
      if (CONV_CYCLES < 1) begin : g_bad_conv
         $error("adc_seq_ctrl: CONV_CYCLES must be positive");
      end
   endgenerate

   // input synchronisation
   logic [NSYNC-1:0] raw_in, syn;
   logic [1:0]       mode_s;
   logic             shdn_n_s, cs_n_s, cv_n_s, rd_n_s, wr_n_s;

   assign raw_in = {mode_sel, shdn_n, cs_n, convst_n, rd_n, wr_n};

   adc_seq_sync #(
      .WIDTH   (NSYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (7'b0011111)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign {mode_s, shdn_n_s, cs_n_s, cv_n_s, rd_n_s, wr_n_s} = syn;

   // mode decode and edge detection
   logic prog_mode, run_mode, direct_mode;
   logic wr_q, rd_q, cv_q, prog_q;
   logic wr_rise, rd_rise, cv_fall, prog_rise;
   cfg_t dir_q;

   assign direct_mode = !mode_s[1];
   assign prog_mode   = mode_s[1] && !mode_s[0];
   assign run_mode    = mode_s[1] &&  mode_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= 1'b1;
         rd_q   <= 1'b1;
         cv_q   <= 1'b1;
         prog_q <= 1'b0;
      end else begin
         wr_q   <= wr_n_s;
         rd_q   <= rd_n_s;
         cv_q   <= cv_n_s;
         prog_q <= prog_mode;
      end
   end

   assign wr_rise   = wr_n_s && !wr_q;
   assign rd_rise   = rd_n_s && !rd_q;
   assign cv_fall   = !cv_n_s && cv_q;
   assign prog_rise = prog_mode && !prog_q;

   // sequence memory
   cfg_t             pin_cfg;
   entry_t           rd_entry;
   logic [PTR_W-1:0] ptr;
   logic             conv_busy, conv_done, conv_start;
   logic             mem_wr, ptr_clr, ptr_inc;
   logic [DATA_W-1:0] conv_res;

   assign pin_cfg = {pin_gain, pin_bip, pin_diff, pin_chan};

   assign mem_wr  = prog_mode && wr_rise;
   assign ptr_clr = prog_rise || (run_mode && conv_done && rd_entry.eos);
   assign ptr_inc = (prog_mode && (wr_rise || (rd_rise && !cs_n_s)))
                 || (run_mode && conv_done && !rd_entry.eos);

   adc_seq_mem #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mem_wr),
      .wdata   ({pin_eos, pin_cfg}),
      .ptr_clr (ptr_clr),
      .ptr_inc (ptr_inc),
      .rdata   (rd_entry),
      .ptr     (ptr)
   );

   // conversion timer
   assign conv_start = cv_fall && !cs_n_s && shdn_n_s && !prog_mode;

   adc_seq_conv #(
      .CYCLES (CONV_CYCLES),
      .DATA_W (DATA_W)
   ) u_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (conv_start),
      .result_in (conv_result),
      .busy      (conv_busy),
      .done      (conv_done),
      .result    (conv_res)
   );

   // direct-mode latch and active setup
   cfg_t act_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     dir_q <= '0;
      else if (direct_mode && wr_rise) dir_q <= pin_cfg;
   end

   always_comb begin
      if (run_mode)                     act_cfg = rd_entry.cfg;
      else if (direct_mode && !wr_n_s)  act_cfg = pin_cfg;
      else                              act_cfg = dir_q;
   end

   assign {act_gain, act_bip, act_diff, act_chan} = act_cfg;

   // data bus
   logic [DATA_W-1:0] rb_word;

   always_comb begin
      rb_word              = '0;
      rb_word[CFG_W-1:0]   = rd_entry.cfg;
      rb_word[DATA_W-1]    = rd_entry.eos;
   end

   assign data_out = prog_mode ? rb_word : conv_res;
   assign data_oe  = !cs_n_s && !rd_n_s;

   // busy and power states
   assign busy_n = !(conv_busy || prog_mode);
   assign nap    = !shdn_n_s && !cs_n_s;
   assign sleep  = !shdn_n_s &&  cs_n_s;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int PTR_W = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             busy_n,
   input logic             prog_mode,
   input logic             run_mode,
   input logic             conv_busy,
   input logic             conv_done,
   input logic             cs_n_s,
   input logic             wr_n_s,
   input logic [PTR_W-1:0] ptr,
   input logic [5:0]       act_word,
   input logic             nap,
   input logic             sleep
);

   assert_busy_in_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_mode |-> !busy_n);

   assert_busy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(prog_mode) && !conv_busy) |-> busy_n);

   assert_ptr_zero_on_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode) |=> (ptr == '0));

   assert_no_start_in_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_mode && !conv_busy) |=> !conv_busy);

   assert_cs_high_read_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_mode && $past(prog_mode) && cs_n_s && wr_n_s && $past(wr_n_s)) |=> $stable(ptr));

   assert_run_setup_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_mode && conv_busy && !conv_done) |=> $stable(act_word));

   assert_power_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nap, sleep}));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_n    (busy_n),
   .prog_mode (prog_mode),
   .run_mode  (run_mode),
   .conv_busy (conv_busy),
   .conv_done (conv_done),
   .cs_n_s    (cs_n_s),
   .wr_n_s    (wr_n_s),
   .ptr       (ptr),
   .act_word  ({act_gain, act_bip, act_diff, act_chan}),
   .nap       (nap),
   .sleep     (sleep)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

   localparam int DEPTH  = 16;
   localparam int DATA_W = 10;
   localparam int CONV   = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, convst_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, shdn_n = 1'b1;
   logic [1:0] mode_sel = 2'b00;
   logic [2:0] pin_chan = '0;
   logic pin_diff = 1'b0, pin_bip = 1'b0, pin_gain = 1'b0, pin_eos = 1'b0;
   logic [DATA_W-1:0] conv_result = '0;
   logic busy_n, act_diff, act_bip, act_gain, data_oe, nap, sleep;
   logic [2:0] act_chan;
   logic [DATA_W-1:0] data_out;

   int nvec = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   adc_seq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst_n(convst_n), .rd_n(rd_n),
      .wr_n(wr_n), .shdn_n(shdn_n), .mode_sel(mode_sel), .pin_chan(pin_chan),
      .pin_diff(pin_diff), .pin_bip(pin_bip), .pin_gain(pin_gain), .pin_eos(pin_eos),
      .conv_result(conv_result), .busy_n(busy_n), .act_chan(act_chan),
      .act_diff(act_diff), .act_bip(act_bip), .act_gain(act_gain),
      .data_out(data_out), .data_oe(data_oe), .nap(nap), .sleep(sleep)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] pat(input int i);
      return {i[1], i[0], i[3], i[2:0]};
   endfunction

   function automatic logic eosf(input int i);
      return (i == 5) || (i == 15);
   endfunction

   // expected memory contents after the programming pass
   function automatic logic [5:0] loc_cfg(input int l);
      return (l == 0) ? pat(20) : pat(l);
   endfunction

   function automatic logic loc_eos(input int l);
      return (l == 0) ? 1'b0 : eosf(l);
   endfunction

   function automatic int act_now();
      return int'({act_gain, act_bip, act_diff, act_chan});
   endfunction

   task automatic set_pins(input logic [5:0] c, input logic e);
      {pin_gain, pin_bip, pin_diff, pin_chan} = c;
      pin_eos = e;
   endtask

   // one conversion: returns number of cycles busy_n was low
   task automatic run_conv(input bit retrigger, output int n);
      int w = 0;
      n = 0;
      convst_n = 1'b0;
      while (busy_n && w < 20) begin step(1); w++; end
      while (!busy_n && n < 200) begin
         step(1);
         n++;
         if (n == 3) convst_n = 1'b1;
         if (retrigger && n == 8) convst_n = 1'b0;
      end
      convst_n = 1'b1;
      step(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      int n;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk("R1 busy_n", busy_n, 1);
      chk("R1 data_oe", data_oe, 0);
      chk("R1 nap", nap, 0);
      chk("R1 sleep", sleep, 0);
      chk("R1 act", act_now(), 0);

      // R11 power states
      shdn_n = 1'b0; cs_n = 1'b0; step(4);
      chk("R11 nap", nap, 1);
      chk("R11 sleep", sleep, 0);
      cs_n = 1'b1; step(4);
      chk("R11 nap", nap, 0);
      chk("R11 sleep", sleep, 1);
      shdn_n = 1'b1; step(4);
      chk("R11 awake", {nap, sleep}, 0);

      // R9 direct mode pass-through and latch
      set_pins(pat(9), 1'b0); wr_n = 1'b0; step(4);
      chk("R9 pass", act_now(), pat(9));
      set_pins(pat(10), 1'b0); step(4);
      chk("R9 pass follow", act_now(), pat(10));
      wr_n = 1'b1; step(4);
      set_pins(pat(3), 1'b0); step(4);
      chk("R9 latched", act_now(), pat(10));

      // R1 memory zero: readback location 0 right after entering program mode
      cs_n = 1'b0;
      mode_sel = 2'b10; step(4);
      rd_n = 1'b0; step(4);
      chk("R1 mem zero", data_out, 0);
      rd_n = 1'b1; step(4);
      mode_sel = 2'b00; step(4);

      // R2 / R5 programming pass with wrap (17 writes)
      mode_sel = 2'b10; step(4);
      chk("R5 busy in prog", busy_n, 0);
      for (int i = 0; i <= DEPTH; i++) begin
         if (i == DEPTH) set_pins(pat(20), 1'b0);
         else            set_pins(pat(i), eosf(i));
         wr_n = 1'b0; step(4);
         wr_n = 1'b1; step(4);
         if (!busy_n) nvec++; else begin nerr++; $display("FAIL R5 actual=1 expected=0"); end
      end

      // R7 conversion start ignored in program mode
      convst_n = 1'b0; step(6);
      convst_n = 1'b1; step(4);

      // R5 busy released on leaving program mode
      mode_sel = 2'b00; step(4);
      chk("R5 busy released", busy_n, 1);
      chk("R7 no conv from prog", busy_n, 1);

      // R3 / R4 readback pass
      mode_sel = 2'b10; step(4);
      for (int i = 0; i < DEPTH; i++) begin
         rd_n = 1'b0; step(4);
         chk("R8 oe", data_oe, 1);
         chk("R4 readback", data_out, int'({loc_eos(i), 3'b000, loc_cfg(i)}));
         rd_n = 1'b1; step(4);
         chk("R8 oe off", data_oe, 0);
      end
      rd_n = 1'b0; step(4);
      chk("R2 wrap", data_out, int'({loc_eos(0), 3'b000, loc_cfg(0)}));
      rd_n = 1'b1; step(4);

      // R8 read strobe with chip select high
      cs_n = 1'b1; step(4);
      rd_n = 1'b0; step(4);
      chk("R8 oe cs high", data_oe, 0);
      rd_n = 1'b1; step(4);
      cs_n = 1'b0; step(4);
      rd_n = 1'b0; step(4);
      chk("R8 no advance", data_out, int'({loc_eos(1), 3'b000, loc_cfg(1)}));
      rd_n = 1'b1; step(4);
      mode_sel = 2'b00; step(4);

      // R6 conversion length and result
      conv_result = 10'h2A5;
      run_conv(1'b0, n);
      chk("R6 busy length", n, CONV);
      rd_n = 1'b0; step(4);
      chk("R6 result", data_out, 10'h2A5);
      chk("R6 oe", data_oe, 1);
      rd_n = 1'b1; step(4);

      // R7 retrigger during conversion ignored
      conv_result = 10'h13C;
      run_conv(1'b1, n);
      chk("R7 retrigger length", n, CONV);
      chk("R7 no second conv", busy_n, 1);
      rd_n = 1'b0; step(4);
      chk("R6 result 2", data_out, 10'h13C);
      rd_n = 1'b1; step(4);

      // R7 ignored with chip select high
      cs_n = 1'b1; step(4);
      convst_n = 1'b0; step(6);
      chk("R7 cs high", busy_n, 1);
      convst_n = 1'b1; step(4);
      cs_n = 1'b0; step(4);

      // R7 ignored in shutdown
      shdn_n = 1'b0; step(4);
      convst_n = 1'b0; step(6);
      chk("R7 shutdown", busy_n, 1);
      convst_n = 1'b1; step(4);
      shdn_n = 1'b1; step(4);

      // R10 run mode sequencing (enter via program mode to start at 0)
      mode_sel = 2'b10; step(4);
      mode_sel = 2'b11; step(4);
      begin
         int loc = 0;
         for (int k = 0; k < 9; k++) begin
            chk("R10 setup", act_now(), loc_cfg(loc));
            run_conv(1'b0, n);
            chk("R10 conv length", n, CONV);
            loc = loc_eos(loc) ? 0 : loc + 1;
         end
      end
      mode_sel = 2'b00; step(4);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule